// File: doc/BRIEF.md
# Mailbox Transaction Sequencer Engine

This block is a bus master that performs one indirect register access through a two-word mailbox: an interface word that takes an opcode and reports busy and response status, and a data word that carries the command argument. A request names a target address, an access kind (control-register read or write, memory-mapped read or write) and write data. The engine turns that request into a fixed chain of four mailbox commands: open, register address, data transfer and close. It returns the data word that was sampled between the transfer and the close commands.

Each command is written as data-word-first, then interface-word-with-run-bit. The engine then reads the interface word back until the run bit drops, waiting a fixed number of clock cycles between reads. A command that never goes idle, or that ends with a response code other than success, is sent again as a whole, up to a bounded number of attempts. A command that runs out of attempts sets a sticky error flag, but the chain still runs through to the close command. Only one request is in flight at a time.

Top module: `mbx_seq_engine`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low from the next cycle until the cycle in which `done` is high. `done` is a one-cycle pulse, and `req_ready` is high again in that same cycle.
- R2: Each command attempt writes the data word (offset `DATA_OFS`, default 0x6C04) first and the interface word (offset `IF_OFS`, default 0x6C00) second. The interface write carries the opcode in bits 7:0 and bit 31 set. Opcode 0x00 is never written.
- R3: The commands are issued in this order, for access kind `req_kind` 0 = control read, 1 = control write, 2 = memory-mapped read, 3 = memory-mapped write, with sequence number = kind + 1. Open is opcode 0x02 with the sequence number. Register is 0x13 / 0x14 / 0x15 / 0x16 for kinds 0 / 1 / 2 / 3, with the address. Transfer is 0x07 with data 0 for reads, or 0x08 with the write data for writes. Close is 0x03 with the sequence number.
- R4: After the interface write, the engine reads the interface word. While bit 31 reads back set, it waits at least `POLL_CYC` = `CLK_FREQ_HZ`·`POLL_US`/10^6 cycles before the next read. It reads at most `MAX_POLLS` (default 100) times per attempt.
- R5: A read with bit 31 clear and bits 15:0 equal to 0x0040 completes the command. The engine then moves to the next command without further reads.
- R6: A read with bit 31 clear and any other response code fails the attempt, and so does bit 31 still set on the `MAX_POLLS`-th read. A failed attempt resends the whole command (data write, then interface write), up to `MAX_TRIES` (default 10) attempts in total.
- R7: When a command fails all `MAX_TRIES` attempts, `err` is set and the remaining commands are still issued through close. `err` stays set until the next request is taken, and is cleared then.
- R8: The data word is read once, after the transfer command completes and before the close command's data write. Its value appears on `rd_data` with `done` and is held until the next sample.
- R9: Each bus access holds `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` steady until `bus_ack`. Read data is taken on `bus_ack`. No bus access is made while `req_ready` is high.
- R10: After reset, `req_ready` = 1, `done` = 0, `err` = 0, `bus_valid` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_addr | input | 32 | Target register address |
| req_kind | input | 2 | Access kind (0 ctrl rd, 1 ctrl wr, 2 mmio rd, 3 mmio wr) |
| req_wdata | input | 32 | Write data for write kinds |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Data word sampled before close |
| err | output | 1 | Sticky: some command exhausted its attempts |
| bus_valid | output | 1 | Bus access requested |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Mailbox word offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |

## Verification
All four access kinds are run with no faults. This shows apart the register opcodes, the sequence numbers, and the transfer opcode and payload for reads against writes. Faults are then placed on single commands:
- bad response codes that recover on a later attempt, which gives a retry without an error;
- bad response codes on every attempt, which gives an error while the chain still runs on;
- a busy flag that never clears, which gives exactly the poll limit per attempt;
- a busy flag that clears on the very last permitted read, or one read too late, which marks the poll-limit boundary from both sides.

A clean request that follows a failed one shows that the error flag is cleared.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

    localparam int MBX_DW  = 32;
    localparam int RUN_BIT = 31;
    localparam logic [15:0] RESP_OK = 16'h0040;

    typedef enum logic [7:0] {
        OP_NONE    = 8'h00,
        OP_OPEN    = 8'h02,
        OP_CLOSE   = 8'h03,
        OP_RD_XFER = 8'h07,
        OP_WR_XFER = 8'h08,
        OP_CSR_RD  = 8'h13,
        OP_CSR_WR  = 8'h14,
        OP_MMIO_RD = 8'h15,
        OP_MMIO_WR = 8'h16
    } mbx_op_e;

    typedef enum logic [1:0] {
        K_CSR_RD  = 2'd0,
        K_CSR_WR  = 2'd1,
        K_MMIO_RD = 2'd2,
        K_MMIO_WR = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPEN, ST_ADDR, ST_XFER, ST_SAMPLE, ST_CLOSE
    } seq_step_e;

    typedef enum logic [2:0] {
        CM_IDLE, CM_LOAD, CM_KICK, CM_POLL, CM_WAIT
    } cmd_state_e;

    typedef struct packed {
        mbx_op_e           op;
        logic [MBX_DW-1:0] payload;
    } mbx_cmd_t;

    function automatic logic [MBX_DW-1:0] seq_num(acc_kind_e k);
        return MBX_DW'(k) + MBX_DW'(1);
    endfunction

    function automatic mbx_op_e addr_op(acc_kind_e k);
        case (k)
            K_CSR_RD:  return OP_CSR_RD;
            K_CSR_WR:  return OP_CSR_WR;
            K_MMIO_RD: return OP_MMIO_RD;
            default:   return OP_MMIO_WR;
        endcase
    endfunction

    function automatic logic is_write(acc_kind_e k);
        return k[0];
    endfunction

    function automatic mbx_op_e xfer_op(acc_kind_e k);
        return is_write(k) ? OP_WR_XFER : OP_RD_XFER;
    endfunction

endpackage

// File: rtl/mbx_cmd_unit.sv
module mbx_cmd_unit
    import mbx_seq_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IF_OFS  = 16'h6C00,
    parameter logic [ADDR_W-1:0] DATA_OFS = 16'h6C04,
    parameter int              POLL_CYC  = 500,
    parameter int              MAX_POLLS = 100,
    parameter int              MAX_TRIES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mbx_cmd_t          cmd_in,
    output logic              fin,
    output logic              ok,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [MBX_DW-1:0] bus_wdata,
    input  logic [MBX_DW-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int WW = $clog2(POLL_CYC + 1);

    cmd_state_e      st;
    mbx_cmd_t        cmd_q;
    logic [PW-1:0]   polls;
    logic [TW-1:0]   tries;
    logic [WW-1:0]   wait_cnt;
    logic            poll_done;
    logic            still_busy;
    logic            attempt_bad;
    logic            attempt_good;

    always_comb begin
        bus_valid = (st == CM_LOAD) || (st == CM_KICK) || (st == CM_POLL);
        bus_write = (st != CM_POLL);
        bus_addr  = (st == CM_LOAD) ? DATA_OFS : IF_OFS;
        case (st)
            CM_LOAD: bus_wdata = cmd_q.payload;
            CM_KICK: bus_wdata = {1'b1, 23'd0, cmd_q.op};
            default: bus_wdata = '0;
        endcase
    end

    assign poll_done    = (st == CM_POLL) && bus_ack;
    assign still_busy   = bus_rdata[RUN_BIT];
    assign attempt_good = poll_done && !still_busy && (bus_rdata[15:0] == RESP_OK);
    assign attempt_bad  = poll_done && (still_busy ? (polls == PW'(MAX_POLLS - 1))
                                                   : (bus_rdata[15:0] != RESP_OK));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CM_IDLE;
            cmd_q    <= '{op: OP_NONE, payload: '0};
            polls    <= '0;
            tries    <= '0;
            wait_cnt <= '0;
            fin      <= 1'b0;
            ok       <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                CM_IDLE: if (start) begin
                    cmd_q <= cmd_in;
                    tries <= '0;
                    st    <= CM_LOAD;
                end
                CM_LOAD: if (bus_ack) st <= CM_KICK;
                CM_KICK: if (bus_ack) begin
                    polls <= '0;
                    st    <= CM_POLL;
                end
                CM_POLL: if (bus_ack) begin
                    polls <= polls + 1'b1;
                    if (attempt_good) begin
                        fin <= 1'b1;
                        ok  <= 1'b1;
                        st  <= CM_IDLE;
                    end else if (attempt_bad) begin
                        if (tries == TW'(MAX_TRIES - 1)) begin
                            fin <= 1'b1;
                            ok  <= 1'b0;
                            st  <= CM_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= CM_LOAD;
                        end
                    end else begin
                        wait_cnt <= '0;
                        st       <= CM_WAIT;
                    end
                end
                CM_WAIT: begin
                    wait_cnt <= wait_cnt + 1'b1;
                    if (wait_cnt == WW'(POLL_CYC - 1)) st <= CM_POLL;
                end
                default: st <= CM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_seq_ctrl.sv
module mbx_seq_ctrl
    import mbx_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MBX_DW-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [MBX_DW-1:0] req_wdata,
    output logic              done,
    output logic [MBX_DW-1:0] rd_data,
    output logic              err,
    output logic              cmd_start,
    output mbx_cmd_t          cmd,
    input  logic              cmd_fin,
    input  logic              cmd_ok,
    output logic              smp_valid,
    input  logic              smp_ack,
    input  logic [MBX_DW-1:0] smp_rdata
);
    seq_step_e         step;
    logic              launched;
    acc_kind_e         kind_q;
    logic [MBX_DW-1:0] addr_q;
    logic [MBX_DW-1:0] wd_q;
    logic              cmd_step;

    assign req_ready = (step == ST_IDLE);
    assign smp_valid = (step == ST_SAMPLE);
    assign cmd_step  = (step == ST_OPEN) || (step == ST_ADDR) ||
                       (step == ST_XFER) || (step == ST_CLOSE);
    assign cmd_start = cmd_step && !launched;

    always_comb begin
        case (step)
            ST_OPEN:  cmd = '{op: OP_OPEN,        payload: seq_num(kind_q)};
            ST_ADDR:  cmd = '{op: addr_op(kind_q), payload: addr_q};
            ST_XFER:  cmd = '{op: xfer_op(kind_q), payload: is_write(kind_q) ? wd_q : '0};
            ST_CLOSE: cmd = '{op: OP_CLOSE,       payload: seq_num(kind_q)};
            default:  cmd = '{op: OP_NONE,        payload: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_IDLE;
            launched <= 1'b0;
            kind_q   <= K_CSR_RD;
            addr_q   <= '0;
            wd_q     <= '0;
            done     <= 1'b0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cmd_start) launched <= 1'b1;
            case (step)
                ST_IDLE: if (req_valid) begin
                    kind_q <= acc_kind_e'(req_kind);
                    addr_q <= req_addr;
                    wd_q   <= req_wdata;
                    err    <= 1'b0;
                    step   <= ST_OPEN;
                end
                ST_SAMPLE: if (smp_ack) begin
                    rd_data <= smp_rdata;
                    step    <= ST_CLOSE;
                end
                default: if (cmd_fin) begin
                    launched <= 1'b0;
                    if (!cmd_ok) err <= 1'b1;
                    case (step)
                        ST_OPEN: step <= ST_ADDR;
                        ST_ADDR: step <= ST_XFER;
                        ST_XFER: step <= ST_SAMPLE;
                        default: begin
                            step <= ST_IDLE;
                            done <= 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/mbx_seq_engine.sv
module mbx_seq_engine
    import mbx_seq_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] IF_OFS      = 16'h6C00,
    parameter logic [ADDR_W-1:0] DATA_OFS    = 16'h6C04,
    parameter int                CLK_FREQ_HZ = 50_000_000,
    parameter int                POLL_US     = 10,
    parameter int                MAX_POLLS   = 100,
    parameter int                MAX_TRIES   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_kind,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic              err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    localparam int POLL_RAW = ((CLK_FREQ_HZ / 1000) * POLL_US) / 1000;
    localparam int POLL_CYC = (POLL_RAW < 1) ? 1 : POLL_RAW;

    logic              cmd_start, cmd_fin, cmd_ok;
    mbx_cmd_t          cmd;
    logic              smp_valid;
    logic              cu_valid, cu_write;
    logic [ADDR_W-1:0] cu_addr;
    logic [MBX_DW-1:0] cu_wdata;

    mbx_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .done      (done),
        .rd_data   (rd_data),
        .err       (err),
        .cmd_start (cmd_start),
        .cmd       (cmd),
        .cmd_fin   (cmd_fin),
        .cmd_ok    (cmd_ok),
        .smp_valid (smp_valid),
        .smp_ack   (bus_ack & smp_valid),
        .smp_rdata (bus_rdata)
    );

    mbx_cmd_unit #(
        .ADDR_W    (ADDR_W),
        .IF_OFS    (IF_OFS),
        .DATA_OFS  (DATA_OFS),
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS),
        .MAX_TRIES (MAX_TRIES)
    ) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .cmd_in    (cmd),
        .fin       (cmd_fin),
        .ok        (cmd_ok),
        .bus_valid (cu_valid),
        .bus_write (cu_write),
        .bus_addr  (cu_addr),
        .bus_wdata (cu_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack & cu_valid)
    );

    assign bus_valid = cu_valid | smp_valid;
    assign bus_write = cu_valid & cu_write;
    assign bus_addr  = cu_valid ? cu_addr : DATA_OFS;
    assign bus_wdata = cu_wdata;
endmodule

// File: rtl/mbx_seq_engine_chk.sv
module mbx_seq_engine_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IF_OFS   = 16'h6C00,
    parameter logic [ADDR_W-1:0] DATA_OFS = 16'h6C04
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack
);
    logic data_armed;

    always_ff @(posedge clk) begin
        if (rst) data_armed <= 1'b0;
        else if (bus_valid && bus_ack && bus_write) data_armed <= (bus_addr == DATA_OFS);
    end

    AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                         // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R1
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);                                              // R1
    AST_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == IF_OFS) |-> data_armed);   // R2
    AST_RUN_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == IF_OFS)
            |-> (bus_wdata[31] && bus_wdata[7:0] != 8'h00));              // R2
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !err);                               // R7
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr)
            && $stable(bus_write) && $stable(bus_wdata)));                // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_valid);                                        // R9
endmodule

bind mbx_seq_engine mbx_seq_engine_chk #(
    .ADDR_W   (ADDR_W),
    .IF_OFS   (IF_OFS),
    .DATA_OFS (DATA_OFS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/mbx_seq_engine_tb_top.sv
module mbx_seq_engine_tb_top;
    localparam int          MAX_POLLS = 100;
    localparam int          MAX_TRIES = 10;
    localparam int          POLL_CYC  = 3;
    localparam logic [15:0] IF_OFS    = 16'h6C00;
    localparam logic [15:0] DATA_OFS  = 16'h6C04;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rd_data;
    logic        err;
    logic        bus_valid, bus_write;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #10 clk = ~clk;

    mbx_seq_engine #(.CLK_FREQ_HZ(300_000)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .err(err),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [7:0]  exp_op[$];
    logic [31:0] exp_dat[$];
    int          exp_polls[$];
    int          plan_busy[$];
    logic [15:0] plan_resp[$];
    logic [31:0] exp_rd[$];
    logic        exp_err[$];

    // mailbox target model state
    logic [31:0] mdata = '0;
    logic        fresh = 1'b0;
    int          busy_left = 0;
    logic [15:0] cur_resp = 16'h0040;
    int          cur_polls = 0;
    logic        att_open = 1'b0;
    int          cyc = 0;
    int          last_poll = 0;
    logic [31:0] seq_q = '0;
    logic [31:0] addr_m = '0;
    logic        done_prev = 1'b0;

    task automatic close_attempt();
        if (att_open) begin
            if (exp_polls.size() == 0) check("R4 poll count (no entry)", 1, 0);
            else check("R4 polls per attempt", cur_polls, exp_polls.pop_front());
        end
        att_open = 1'b0;
    endtask

    task automatic on_cmd(input logic [31:0] w);
        check("R2 run bit set", {31'd0, w[31]}, 1);
        check("R2 data written first", {31'd0, fresh}, 1);
        if (w[7:0] == 8'h00) check("R2 zero opcode", 1, 0);
        if (exp_op.size() == 0) begin
            check("R3 unexpected command", {24'd0, w[7:0]}, 0);
        end else begin
            check("R3 opcode order", {24'd0, w[7:0]}, {24'd0, exp_op.pop_front()});
            check("R3 command payload", mdata, exp_dat.pop_front());
        end
        close_attempt();
        att_open  = 1'b1;
        cur_polls = 0;
        fresh     = 1'b0;
        busy_left = (plan_busy.size() != 0) ? plan_busy.pop_front() : 1;
        cur_resp  = (plan_resp.size() != 0) ? plan_resp.pop_front() : 16'h0040;
        case (w[7:0])
            8'h02: seq_q = mdata;
            8'h13, 8'h15: addr_m = mdata;
            8'h07: mdata = addr_m ^ (seq_q << 28);
            default: ;
        endcase
    endtask

    task automatic on_poll();
        cur_polls++;
        if (cur_polls > 1)
            check("R4 poll spacing", {31'd0, (cyc - last_poll) >= POLL_CYC}, 1);
        last_poll = cyc;
        if (busy_left > 0) begin
            bus_rdata = {1'b1, 15'd0, 16'h0080};
            busy_left--;
        end else begin
            bus_rdata = {16'd0, cur_resp};
        end
    endtask

    // responder and result monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_valid) begin
                bus_ack = 1'b1;
                if (bus_write && bus_addr == DATA_OFS) begin
                    mdata = bus_wdata;
                    fresh = 1'b1;
                end else if (bus_write && bus_addr == IF_OFS) begin
                    on_cmd(bus_wdata);
                end else if (!bus_write && bus_addr == IF_OFS) begin
                    on_poll();
                end else begin
                    check("R8 sample before close", {31'd0, exp_op.size() == 1 && exp_op[0] == 8'h03}, 1);
                    bus_rdata = mdata;
                end
            end
            if (req_ready && bus_valid) check("R9 bus quiet while idle", 1, 0);
            if (done) begin
                close_attempt();
                if (done_prev) check("R1 done width", 1, 0);
                check("R1 ready with done", {31'd0, req_ready}, 1);
                check("R3 all commands issued", exp_op.size(), 0);
                if (exp_rd.size() == 0) check("R1 unexpected done", 1, 0);
                else begin
                    check("R8 read data", rd_data, exp_rd.pop_front());
                    check("R7 error flag", {31'd0, err}, {31'd0, exp_err.pop_front()});
                end
            end
            done_prev = done;
        end
    end

    task automatic run_req(input logic [1:0] kind, input logic [31:0] addr, input logic [31:0] wd,
                           input int fcmd, input int fn, input int fbusy, input logic [15:0] fresp);
        logic        err_e;
        logic [7:0]  op;
        logic [31:0] dat;
        logic        bad, failed;
        int          b;
        logic [15:0] r;
        err_e = 1'b0;
        for (int i = 0; i < 4; i++) begin
            case (i)
                0: begin op = 8'h02; dat = {30'd0, kind} + 32'd1; end
                1: begin op = 8'h13 + {6'd0, kind}; dat = addr; end
                2: begin op = kind[0] ? 8'h08 : 8'h07; dat = kind[0] ? wd : 32'd0; end
                default: begin op = 8'h03; dat = {30'd0, kind} + 32'd1; end
            endcase
            for (int t = 0; t < MAX_TRIES; t++) begin
                bad = (i == fcmd) && (t < fn);
                b   = bad ? fbusy : 1;
                r   = bad ? fresp : 16'h0040;
                plan_busy.push_back(b);
                plan_resp.push_back(r);
                exp_op.push_back(op);
                exp_dat.push_back(dat);
                exp_polls.push_back((b + 1 > MAX_POLLS) ? MAX_POLLS : b + 1);
                failed = (b >= MAX_POLLS) || (r != 16'h0040);
                if (failed && t == MAX_TRIES - 1) err_e = 1'b1;
                if (!failed) break;
            end
        end
        exp_rd.push_back(kind[0] ? wd : (addr ^ (({30'd0, kind} + 32'd1) << 28)));
        exp_err.push_back(err_e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 ready low after accept", {31'd0, req_ready}, 0);
        while (exp_rd.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset ready", {31'd0, req_ready}, 1);
        check("R10 reset done", {31'd0, done}, 0);
        check("R10 reset err", {31'd0, err}, 0);
        check("R10 reset bus idle", {31'd0, bus_valid}, 0);
        check("R10 reset rd_data", rd_data, 0);
        // R3 / R5 / R8: all four kinds, no faults
        run_req(2'd0, 32'h0000_0100, 32'h1111_1111, -1, 0, 0, 16'h0040);
        run_req(2'd1, 32'h0000_2040, 32'hCAFE_0001, -1, 0, 0, 16'h0040);
        run_req(2'd2, 32'h0ED0_0010, 32'h2222_2222, -1, 0, 0, 16'h0040);
        run_req(2'd3, 32'h0ED0_0ABC, 32'h1234_5678, -1, 0, 0, 16'h0040);
        // R6: transfer command rejected twice, then accepted
        run_req(2'd0, 32'h0000_0300, 32'h0, 2, 2, 0, 16'h0090);
        // R7: open rejected on every attempt, chain still completes
        run_req(2'd3, 32'h0000_0444, 32'h5555_AAAA, 0, MAX_TRIES, 0, 16'h0082);
        // R7: error cleared by the next clean request
        run_req(2'd1, 32'h0000_0500, 32'h0F0F_0F0F, -1, 0, 0, 16'h0040);
        // R4 / R6 / R7: register command never goes idle
        run_req(2'd2, 32'h0000_0600, 32'h0, 1, MAX_TRIES, 1000, 16'h0040);
        // R4 / R5: close goes idle on the last permitted read
        run_req(2'd0, 32'h0000_0700, 32'h0, 3, 1, MAX_POLLS - 1, 16'h0040);
        // R4 / R6: busy one read too long, one retry recovers
        run_req(2'd1, 32'h0000_0800, 32'hABCD_EF01, 1, 1, MAX_POLLS, 16'h0040);
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule